// File: doc/BRIEF.md
# Write-Protect Register Unlock Sequencer

This block guards the protection register of a serial memory with a 4 KB array. A bus front end, which is not part of this block, hands it decoded byte writes. Each write carries a 16-bit address, a data byte and a flag that tells whether the write ended with a STOP or with a repeated START. The block holds two volatile latches: a write-enable latch and a register-write-enable latch. It also holds three nonvolatile lock bits: a two-bit block-lock field and a pin-protect enable. The nonvolatile bits are modelled as registers that only a separate cell-initialise input can clear.

A change to the lock bits needs a staged unlock. First the write-enable latch is set, then the register-write-enable latch, and then a commit byte is written. A commit runs for a fixed number of cycles. While it runs the block refuses every transaction, so the master can poll for the acknowledge. A commit is aborted in two cases: it ends in a repeated START, or the protect pin is high while the pin-protect enable is set. The stored block-lock field selects which part of the array refuses writes. The block answers each array write with a combinational grant.

Top module: `wpr_seq`

## Requirements
- R1: When `rst_n` is asserted, both volatile latches and `busy` are cleared, and `blk_lock` and `wpen` keep their values. Only `nv_init_n` clears the nonvolatile bits. Both resets take effect after a two-flop release synchroniser.
- R2: With the register-write-enable latch clear, an accepted write of 8'h02 to address 16'hFFFF sets `wel`.
- R3: An accepted write of 8'h06 to 16'hFFFF sets `rwel` only when `wel` is already set. With `wel` clear it changes nothing.
- R4: With `rwel` clear, an accepted write to 16'hFFFF whose bit 1 is 0 clears `wel`.
- R5: With `rwel` set, a commit starts on an accepted write to 16'hFFFF when four conditions hold: bit 2 is 0, bit 1 is 1, the write ends in STOP, and either `wp_pin` or the stored `wpen` is low. On the next cycle `rwel` falls and `busy` rises. `busy` stays high for exactly TWC_CYCLES cycles. When it falls, `wpen` takes data bit 7 and `blk_lock` takes data bits 4:3, with bit 4 as the high bit.
- R6: With `rwel` set, a write to 16'hFFFF whose bit 2 is 1, or whose bit 1 is 0, changes nothing. `rwel` stays set.
- R7: A commit-shaped write that ends in a repeated START (`txn_stop` = 0) is dropped. `rwel` stays set, `busy` stays low, and the lock bits do not change.
- R8: A commit attempted while `wp_pin` is high and the stored `wpen` is 1 is dropped. `rwel` stays set and no nonvolatile bit changes.
- R9: `txn_ack` equals `txn_valid` while `busy` is low and is 0 while `busy` is high. A transaction that is not acknowledged changes no state.
- R10: `arr_grant` is high only for a valid, acknowledged write to an address other than 16'hFFFF, with `wel` set, whose low 12 address bits lie outside the locked range. The locked ranges are: `blk_lock` 00 locks nothing, 01 locks C00h–FFFh, 10 locks 800h–FFFh, and 11 locks the whole array.
- R11: A write of 8'h02 while `rwel` is set is a commit. Under the R5 conditions it programs `wpen` and `blk_lock` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low operational reset |
| nv_init_n | input | 1 | Asynchronous active-low initialise of the modelled nonvolatile bits |
| txn_valid | input | 1 | One-cycle strobe: a decoded byte write is present |
| txn_addr | input | 16 | Write address |
| txn_data | input | 8 | Write data byte |
| txn_stop | input | 1 | 1 = ended in STOP, 0 = ended in repeated START |
| wp_pin | input | 1 | Write-protect pin level |
| txn_ack | output | 1 | Transaction acknowledged |
| arr_grant | output | 1 | Array write permitted |
| busy | output | 1 | Nonvolatile commit in progress |
| wel | output | 1 | Write-enable latch |
| rwel | output | 1 | Register-write-enable latch |
| blk_lock | output | 2 | Stored block-lock field |
| wpen | output | 1 | Stored pin-protect enable |

## Verification
The latches are visible at the ports, so a wrong unlock state shows on `wel` or `rwel` one cycle after the write that caused it. A wrong commit decision shows on `busy` in that same cycle. A faulty commit timer shows as a `busy` pulse of the wrong length. A wrong nonvolatile value appears only when `busy` falls. After that, array grants read it back: the bench probes addresses just inside and just outside each locked range, which exposes an off-by-one decode immediately.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  localparam logic [15:0] REG_ADDR     = 16'hFFFF;
  localparam logic [7:0]  CMD_SET_WEL  = 8'h02;
  localparam logic [7:0]  CMD_SET_RWEL = 8'h06;
  localparam int          BIT_RWEL     = 2;
  localparam int          BIT_WEL      = 1;
  localparam int          BIT_WPEN     = 7;
  localparam int          BIT_BL_HI    = 4;
  localparam int          BIT_BL_LO    = 3;

  typedef logic [1:0] blk_t;
endpackage

// File: rtl/wpr_rst_sync.sv
module wpr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/wpr_latch_ctl.sv
module wpr_latch_ctl
  import wpr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txn_valid,
  input  logic       busy,
  input  logic       is_reg,
  input  logic [7:0] data,
  input  logic       stop,
  input  logic       wp_pin,
  input  logic       wpen_q,
  output logic       wel,
  output logic       rwel,
  output logic       commit_go,
  output logic       commit_wpen,
  output blk_t       commit_bl
);
  logic wel_q, rwel_q, wel_d, rwel_d, fire, reg_fire, shape_ok, pin_block;

  assign fire      = txn_valid && !busy;
  assign reg_fire  = fire && is_reg;
  assign shape_ok  = !data[BIT_RWEL] && data[BIT_WEL];
  assign pin_block = wp_pin && wpen_q;

  always_comb begin
    wel_d     = wel_q;
    rwel_d    = rwel_q;
    commit_go = 1'b0;
    if (reg_fire) begin
      if (rwel_q) begin
        if (shape_ok && stop && !pin_block) begin
          commit_go = 1'b1;
          rwel_d    = 1'b0;
        end
      end else if (!data[BIT_WEL]) begin
        wel_d = 1'b0;
      end else if (data == CMD_SET_WEL) begin
        wel_d = 1'b1;
      end else if (data == CMD_SET_RWEL && wel_q) begin
        rwel_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else if (reg_fire) begin
      wel_q  <= wel_d;
      rwel_q <= rwel_d;
    end
  end

  assign wel         = wel_q;
  assign rwel        = rwel_q;
  assign commit_wpen = data[BIT_WPEN];
  assign commit_bl   = {data[BIT_BL_HI], data[BIT_BL_LO]};

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && txn_valid) |=> ($stable(wel_q) && $stable(rwel_q)));
  // R7
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rwel_q && reg_fire && shape_ok && !stop) |=> rwel_q);
  // R8
  pin_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rwel_q && reg_fire && wp_pin && wpen_q) |=> rwel_q);
endmodule

// File: rtl/wpr_nv_commit.sv
module wpr_nv_commit
  import wpr_pkg::*;
#(
  parameter int TWC_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nv_rst_n,
  input  logic go,
  input  logic wpen_in,
  input  blk_t bl_in,
  output logic busy,
  output logic wpen,
  output blk_t bl
);
  localparam int CW = $clog2(TWC_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en, pend_en, nv_en;
  logic          pend_wpen_q, nv_wpen_q;
  blk_t          pend_bl_q, nv_bl_q;

  assign busy    = (cnt_q != '0);
  assign pend_en = go && !busy;
  assign cnt_en  = pend_en || busy;
  assign nv_en   = (cnt_q == CW'(1));

  always_comb begin
    if (pend_en) cnt_d = CW'(TWC_CYCLES);
    else         cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_wpen_q <= 1'b0;
      pend_bl_q   <= '0;
    end else if (pend_en) begin
      pend_wpen_q <= wpen_in;
      pend_bl_q   <= bl_in;
    end
  end

  always_ff @(posedge clk or negedge nv_rst_n) begin
    if (!nv_rst_n) begin
      nv_wpen_q <= 1'b0;
      nv_bl_q   <= '0;
    end else if (nv_en && rst_n) begin
      nv_wpen_q <= pend_wpen_q;
      nv_bl_q   <= pend_bl_q;
    end
  end

  assign wpen = nv_wpen_q;
  assign bl   = nv_bl_q;

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
    pend_en |=> busy);
  // R5
  nv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
    !busy |=> ($stable(nv_wpen_q) && $stable(nv_bl_q)));
endmodule

// File: rtl/wpr_lock_decode.sv
module wpr_lock_decode
  import wpr_pkg::*;
#(
  parameter int AW = 12
) (
  input  blk_t          bl,
  input  logic [AW-1:0] addr,
  output logic          locked
);
  localparam int TOP = AW - 1;

  logic in_upper_half, in_upper_quarter;

  generate
    if (AW >= 2) begin : g_wide
      assign in_upper_half    = addr[TOP];
      assign in_upper_quarter = addr[TOP] && addr[TOP-1];
    end else begin : g_narrow
      assign in_upper_half    = addr[TOP];
      assign in_upper_quarter = addr[TOP];
    end
  endgenerate

  always_comb begin
    unique case (bl)
      2'b00:   locked = 1'b0;
      2'b01:   locked = in_upper_quarter;
      2'b10:   locked = in_upper_half;
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpr_seq.sv
module wpr_seq
  import wpr_pkg::*;
#(
  parameter int TWC_CYCLES = 50,
  parameter int ARR_AW     = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nv_init_n,
  input  logic        txn_valid,
  input  logic [15:0] txn_addr,
  input  logic [7:0]  txn_data,
  input  logic        txn_stop,
  input  logic        wp_pin,
  output logic        txn_ack,
  output logic        arr_grant,
  output logic        busy,
  output logic        wel,
  output logic        rwel,
  output logic [1:0]  blk_lock,
  output logic        wpen
);
  logic op_rst_n, nv_rst_n, is_reg, go, c_wpen, locked;
  blk_t c_bl, bl_q;
  logic busy_w, wel_w, rwel_w, wpen_w;

  wpr_rst_sync #(.STAGES(2)) u_op_sync (.clk(clk), .arst_n(rst_n),     .srst_n(op_rst_n));
  wpr_rst_sync #(.STAGES(2)) u_nv_sync (.clk(clk), .arst_n(nv_init_n), .srst_n(nv_rst_n));

  assign is_reg = (txn_addr == REG_ADDR);

  wpr_latch_ctl u_latch (
    .clk(clk), .rst_n(op_rst_n), .txn_valid(txn_valid), .busy(busy_w),
    .is_reg(is_reg), .data(txn_data), .stop(txn_stop), .wp_pin(wp_pin),
    .wpen_q(wpen_w), .wel(wel_w), .rwel(rwel_w), .commit_go(go),
    .commit_wpen(c_wpen), .commit_bl(c_bl)
  );

  wpr_nv_commit #(.TWC_CYCLES(TWC_CYCLES)) u_nv (
    .clk(clk), .rst_n(op_rst_n), .nv_rst_n(nv_rst_n), .go(go),
    .wpen_in(c_wpen), .bl_in(c_bl), .busy(busy_w), .wpen(wpen_w), .bl(bl_q)
  );

  wpr_lock_decode #(.AW(ARR_AW)) u_dec (
    .bl(bl_q), .addr(txn_addr[ARR_AW-1:0]), .locked(locked)
  );

  assign txn_ack   = txn_valid && !busy_w;
  assign arr_grant = txn_ack && !is_reg && wel_w && !locked;
  assign busy      = busy_w;
  assign wel       = wel_w;
  assign rwel      = rwel_w;
  assign blk_lock  = bl_q;
  assign wpen      = wpen_w;

  // R10
  full_lock_chk: assert property (@(posedge clk) disable iff (!op_rst_n)
    arr_grant |-> (bl_q != 2'b11));
  // R5
  commit_clear_chk: assert property (@(posedge clk) disable iff (!op_rst_n || !nv_rst_n)
    go |=> (busy_w && !rwel_w));
endmodule

// File: tb/wpr_seq_test.sv
module wpr_seq_test;
  localparam int TWC = 8;

  logic clk = 1'b0;
  logic rst_n, nv_init_n, txn_valid, txn_stop, wp_pin;
  logic [15:0] txn_addr;
  logic [7:0]  txn_data;
  logic txn_ack, arr_grant, busy, wel, rwel, wpen;
  logic [1:0] blk_lock;

  int n_tests = 0;
  int n_fail  = 0;
  logic got_ack, got_grant;

  always #5 clk = ~clk;

  wpr_seq #(.TWC_CYCLES(TWC), .ARR_AW(12)) uut (
    .clk(clk), .rst_n(rst_n), .nv_init_n(nv_init_n), .txn_valid(txn_valid),
    .txn_addr(txn_addr), .txn_data(txn_data), .txn_stop(txn_stop), .wp_pin(wp_pin),
    .txn_ack(txn_ack), .arr_grant(arr_grant), .busy(busy), .wel(wel), .rwel(rwel),
    .blk_lock(blk_lock), .wpen(wpen)
  );

  // vector: addr, data, stop, wp, exp_ack, exp_wel, exp_rwel, exp_busy
  localparam int NV = 9;
  localparam logic [29:0] VEC [NV] = '{
    {16'hFFFF, 8'h06, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 no wel
    {16'hFFFF, 8'h02, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R2
    {16'hFFFF, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R4
    {16'hFFFF, 8'h02, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R2
    {16'hFFFF, 8'h06, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R3
    {16'hFFFF, 8'h1E, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R6 bit2 set
    {16'hFFFF, 8'h1A, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R7 START
    {16'hFFFF, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R6 bit1 clear
    {16'hFFFF, 8'h9A, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}   // R5 wp high, wpen 0
  };

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic txn(input logic [15:0] a, input logic [7:0] d, input logic s, input logic w);
    @(negedge clk);
    txn_addr = a; txn_data = d; txn_stop = s; wp_pin = w; txn_valid = 1'b1;
    #1;
    got_ack = txn_ack; got_grant = arr_grant;
    @(negedge clk);
    txn_valid = 1'b0; wp_pin = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic commit(input logic [7:0] d);
    int n;
    txn(16'hFFFF, 8'h06, 1'b1, 1'b0);
    txn(16'hFFFF, d, 1'b1, 1'b0);
    wait_idle(n);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; nv_init_n = 1'b0; txn_valid = 1'b0; txn_stop = 1'b1;
    wp_pin = 1'b0; txn_addr = '0; txn_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; nv_init_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset wel", wel, 0);
    check("R1 reset rwel", rwel, 0);
    check("R1 reset busy", busy, 0);
    check("R1 init lock", blk_lock, 0);

    for (int i = 0; i < NV; i++) begin
      txn(VEC[i][29:14], VEC[i][13:6], VEC[i][5], VEC[i][4]);
      check($sformatf("R9 vec%0d ack", i), got_ack, VEC[i][3]);
      check($sformatf("R2-4 vec%0d wel", i), wel, VEC[i][2]);
      check($sformatf("R3/R6/R7 vec%0d rwel", i), rwel, VEC[i][1]);
      check($sformatf("R5 vec%0d busy", i), busy, VEC[i][0]);
    end

    // R9: refused while busy, no state change
    txn(16'hFFFF, 8'h00, 1'b1, 1'b0);
    check("R9 nack busy", got_ack, 0);
    check("R9 wel kept", wel, 1);
    wait_idle(n);
    check("R5 wpen", wpen, 1);
    check("R5 lock", blk_lock, 3);

    // R10 full lock
    txn(16'h0000, 8'h55, 1'b1, 1'b0);
    check("R10 full lock 000", got_grant, 0);

    // R8 wp high, wpen 1: commit dropped
    txn(16'hFFFF, 8'h06, 1'b1, 1'b0);
    txn(16'hFFFF, 8'h02, 1'b1, 1'b1);
    check("R8 rwel kept", rwel, 1);
    check("R8 no busy", busy, 0);
    repeat (TWC + 2) @(negedge clk);
    check("R8 wpen kept", wpen, 1);
    check("R8 lock kept", blk_lock, 3);

    // R11 zero commit with wp low, busy length R5
    txn(16'hFFFF, 8'h02, 1'b1, 1'b0);
    check("R11 rwel cleared", rwel, 0);
    wait_idle(n);
    check("R5 busy cycles", n, TWC);
    check("R11 wpen zero", wpen, 0);
    check("R11 lock zero", blk_lock, 0);
    txn(16'h0FFF, 8'h11, 1'b1, 1'b0);
    check("R10 no lock FFF", got_grant, 1);

    commit(8'h0A);
    check("R5 lock 01", blk_lock, 1);
    txn(16'h0BFF, 8'h11, 1'b1, 1'b0);
    check("R10 q BFF", got_grant, 1);
    txn(16'h0C00, 8'h11, 1'b1, 1'b0);
    check("R10 q C00", got_grant, 0);

    commit(8'h12);
    check("R5 lock 10", blk_lock, 2);
    txn(16'h07FF, 8'h11, 1'b1, 1'b0);
    check("R10 h 7FF", got_grant, 1);
    txn(16'h0800, 8'h11, 1'b1, 1'b0);
    check("R10 h 800", got_grant, 0);

    txn(16'hFFFF, 8'h00, 1'b1, 1'b0);
    check("R4 wel clear", wel, 0);
    txn(16'h0000, 8'h11, 1'b1, 1'b0);
    check("R10 no wel", got_grant, 0);

    // R1 reset keeps nonvolatile bits
    txn(16'hFFFF, 8'h02, 1'b1, 1'b0);
    txn(16'hFFFF, 8'h06, 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 wel after reset", wel, 0);
    check("R1 rwel after reset", rwel, 0);
    check("R1 lock kept", blk_lock, 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule